// File: doc/BRIEF.md
# HDLC Receive Deframer

This block is the receive front end for a bit-oriented HDLC link. It takes one serial bit per strobe and hunts for the flag octet 0x7E to find frame boundaries. Inside a frame it deletes the zero bits the transmitter inserted and packs the remaining bits into octets. The frame body goes out as a byte stream with start and end markers. Every body octet, and the two trailing frame-check octets, feed a CRC-16 over x16 + x12 + x5 + 1. Each frame that is delivered ends with a status code: good, FCS error, or abort.

The two check octets are not delivered, so the block holds the last three octets it received. A body byte leaves once three more octets have come in behind it. The last body byte goes out together with the end marker. A run of seven ones inside a frame aborts it. A single flag may close one frame and open the next. Frames shorter than four octets are dropped without any output. An enable input gates everything: while it is low the block sits idle, and after it returns the block starts hunting for a fresh flag.

Top module: `hdlc_deframer`

## Requirements
- R1: While `enable` is low, no output pulse is produced and any partial frame is discarded. After `enable` returns high, no frame is delivered until a new opening flag arrives, and a flag sent while `enable` was low has no effect.
- R2: After reset or an abort, bits that arrive before the first flag produce no bytes and no flag report.
- R3: Inside a frame, a 0 that follows five consecutive 1s is removed from the data.
- R4: Octets are assembled with the first received bit as bit 0. `frame_start` pulses together with `byte_valid` on the first body byte. With a continuous strobe and no deleted zeros, the first body byte appears nine cycles after the sampling edge of the last bit of the fourth octet.
- R5: The two check octets are never delivered. The last body byte comes out in the same cycle as `frame_end`.
- R6: The CRC is preset to 0xFFFF at each frame start and runs over every octet, check octets included. A final value of 0xF0B8 with a whole number of octets gives `frame_status` 1 (good).
- R7: A frame of four or more octets with any other CRC remainder, or with leftover bits that do not fill an octet, ends with `frame_status` 2 (FCS error).
- R8: Seven consecutive 1s inside a frame pulse `abort_seen` and return the block to flag hunting. If `frame_start` was already given, `frame_end` pulses with `frame_status` 3 and no byte.
- R9: Every flag accepted while enabled pulses `flag_seen`. `flag_seen`, `frame_end` and `abort_seen` appear two cycles after the sampling edge of the bit that completes the flag or the abort run.
- R10: One flag can both close a frame and open the next one. `byte_valid` is low in the cycle after `frame_end`.
- R11: A frame with fewer than four octets between its flags produces no start, byte or end output.
- R12: `frame_status` is 0 whenever `frame_end` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Receiver enable; low holds the block idle and clears the current frame |
| bit_in | input | 1 | Serial line bit |
| bit_valid | input | 1 | Marks a cycle in which `bit_in` carries a bit |
| byte_out | output | 8 | Body byte, first received bit in bit 0 |
| byte_valid | output | 1 | `byte_out` is valid this cycle |
| frame_start | output | 1 | Pulses with the first body byte |
| frame_end | output | 1 | Pulses when a delivered frame ends |
| frame_status | output | 2 | With `frame_end`: 1 good, 2 FCS error, 3 abort; 0 otherwise |
| flag_seen | output | 1 | Pulses once for each flag accepted |
| abort_seen | output | 1 | Pulses once for each abort inside a frame |

## Verification
Flag, end and abort results are due two cycles after the edge that samples their completing bit. A body byte is due nine cycles after its third following octet ends, because its bits first travel through an eight-bit window. The bench stamps the sampling edge of each bit it drives, and a negedge monitor stamps each output pulse. The latency checks compare the two stamps for exact differences of 2 and 9. All other checks wait out several idle cycles and then compare the collected byte sequence, counts and status against values worked out in the bench.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int          OCTET_W       = 8;
    localparam int          CRC_W         = 16;
    localparam int          STUFF_RUN     = 5;
    localparam int          FLAG_RUN      = 6;
    localparam int          MIN_OCTETS    = 4;
    localparam int          HOLD_DEPTH    = MIN_OCTETS - 1;
    localparam int          CNT_W         = $clog2(MIN_OCTETS + 1);
    localparam logic [CRC_W-1:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_RV = 16'h8408;
    localparam logic [CRC_W-1:0] CRC_GOOD    = 16'hF0B8;

    typedef enum logic [1:0] {
        FS_NONE    = 2'd0,
        FS_GOOD    = 2'd1,
        FS_FCS_ERR = 2'd2,
        FS_ABORT   = 2'd3
    } frame_status_e;

    // Advance the bit-reversed CRC-16 by one octet, bit 0 first.
    function automatic logic [CRC_W-1:0] crc16_octet(input logic [CRC_W-1:0] c,
                                                     input logic [OCTET_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < OCTET_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_RV;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_bit_delineator.sv
// Bit-level delineation. It counts runs of ones to spot flags, aborts and
// stuffed zeros. Data bits leave through an eight-bit window, so a flag's
// own bits can be cancelled before they ever reach the octet packer.
// Assumes one line bit per bit_valid cycle. In hunt mode no data leaves.
module hdlc_bit_delineator
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_in,
    input  logic bit_valid,
    output logic data_bit,
    output logic data_ok,
    output logic flag_hit,
    output logic abort_hit
);
    localparam int RUN_W = 3;

    logic [RUN_W-1:0]   ones_q;
    logic [OCTET_W-1:0] win_q;
    logic [OCTET_W-1:0] vld_q;
    logic               in_frame_q;
    logic               strobe;
    logic               stuffed;

    // Decode events from the current bit and the length of the run of ones.
    always_comb begin
        strobe    = bit_valid && enable;
        flag_hit  = strobe && !bit_in && (ones_q == RUN_W'(FLAG_RUN));
        abort_hit = strobe && bit_in && in_frame_q && (ones_q == RUN_W'(FLAG_RUN));
        stuffed   = !bit_in && (ones_q == RUN_W'(STUFF_RUN));
        data_bit  = win_q[OCTET_W-1];
        data_ok   = strobe && in_frame_q && vld_q[OCTET_W-1];
    end

    // Update the run counter, the delay window and the hunt/frame state.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            ones_q     <= '0;
            win_q      <= '0;
            vld_q      <= '0;
            in_frame_q <= 1'b0;
        end else if (bit_valid) begin
            if (!bit_in)                     ones_q <= '0;
            else if (ones_q != {RUN_W{1'b1}}) ones_q <= ones_q + 1'b1;
            win_q <= {win_q[OCTET_W-2:0], bit_in};
            if (flag_hit || abort_hit) vld_q <= '0;
            else                       vld_q <= {vld_q[OCTET_W-2:0], !stuffed};
            if (flag_hit)       in_frame_q <= 1'b1;
            else if (abort_hit) in_frame_q <= 1'b0;
        end
    end

    assert_stuff_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && enable && !bit_in && ones_q == RUN_W'(STUFF_RUN)) |=> !vld_q[0]);

    assert_abort_hunts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> !in_frame_q);

endmodule

// File: rtl/hdlc_octet_packer.sv
// Packs destuffed data bits into octets, first bit into bit 0. It registers
// each finished octet and the flag/abort events in the same stage. On a
// flag it records whether the frame ended on an octet boundary.
module hdlc_octet_packer
    import hdlc_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               data_bit,
    input  logic               data_ok,
    input  logic               flag_hit,
    input  logic               abort_hit,
    output logic [OCTET_W-1:0] oct_q,
    output logic               oct_stb_q,
    output logic               flag_ev_q,
    output logic               abort_ev_q,
    output logic               aligned_q
);
    localparam int BIT_CNT_W = $clog2(OCTET_W);

    logic [OCTET_W-1:0]   sh_q, sh_n;
    logic [BIT_CNT_W-1:0] cnt_q, cnt_n;

    // Next shift value and bit count after the current data bit.
    always_comb begin
        sh_n  = sh_q;
        cnt_n = cnt_q;
        if (data_ok) begin
            sh_n  = {data_bit, sh_q[OCTET_W-1:1]};
            cnt_n = cnt_q + 1'b1;
        end
    end

    // Register the finished octet, the events, and the alignment at a flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            oct_q      <= '0;
            oct_stb_q  <= 1'b0;
            flag_ev_q  <= 1'b0;
            abort_ev_q <= 1'b0;
            aligned_q  <= 1'b0;
        end else begin
            sh_q       <= sh_n;
            oct_stb_q  <= data_ok && (cnt_q == {BIT_CNT_W{1'b1}});
            if (data_ok && (cnt_q == {BIT_CNT_W{1'b1}})) oct_q <= sh_n;
            flag_ev_q  <= flag_hit;
            abort_ev_q <= abort_hit;
            aligned_q  <= (cnt_n == '0);
            cnt_q      <= (flag_hit || abort_hit) ? '0 : cnt_n;
        end
    end

    assert_flag_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ev_q |-> (cnt_q == '0));

endmodule

// File: rtl/hdlc_frame_tracker.sv
// Frame-level tracking: CRC, octet count and a three-octet hold line that
// keeps the check octets back from the output. Flag and abort events are
// delayed one cycle here, so a frame close never meets an octet delivery
// in the same cycle. Assumes at most one octet per eight bit strobes.
module hdlc_frame_tracker
    import hdlc_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [OCTET_W-1:0] oct,
    input  logic               oct_stb,
    input  logic               flag_ev,
    input  logic               abort_ev,
    input  logic               aligned,
    output logic [OCTET_W-1:0] byte_out,
    output logic               byte_valid,
    output logic               frame_start,
    output logic               frame_end,
    output frame_status_e      frame_status,
    output logic               flag_seen,
    output logic               abort_seen
);
    logic [OCTET_W-1:0] hold_q [HOLD_DEPTH];
    logic [CNT_W-1:0]   cnt_q;
    logic [CRC_W-1:0]   crc_q;
    logic               flag_pend_q;
    logic               abort_pend_q;
    logic               aligned_pend_q;
    logic               full;

    // A frame counts as started once it has reached the minimum length.
    always_comb full = (cnt_q == CNT_W'(MIN_OCTETS));

    // Deliver held octets, check the CRC at close and report each event.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            for (int i = 0; i < HOLD_DEPTH; i++) hold_q[i] <= '0;
            cnt_q          <= '0;
            crc_q          <= CRC_PRESET;
            flag_pend_q    <= 1'b0;
            abort_pend_q   <= 1'b0;
            aligned_pend_q <= 1'b0;
            byte_out       <= '0;
            byte_valid     <= 1'b0;
            frame_start    <= 1'b0;
            frame_end      <= 1'b0;
            frame_status   <= FS_NONE;
            flag_seen      <= 1'b0;
            abort_seen     <= 1'b0;
        end else begin
            byte_valid     <= 1'b0;
            frame_start    <= 1'b0;
            frame_end      <= 1'b0;
            frame_status   <= FS_NONE;
            flag_seen      <= 1'b0;
            abort_seen     <= 1'b0;
            flag_pend_q    <= flag_ev;
            abort_pend_q   <= abort_ev;
            aligned_pend_q <= aligned;
            if (oct_stb) begin
                crc_q <= crc16_octet(crc_q, oct);
                for (int i = HOLD_DEPTH - 1; i > 0; i--) hold_q[i] <= hold_q[i-1];
                hold_q[0] <= oct;
                if (!full) cnt_q <= cnt_q + 1'b1;
                if (cnt_q >= CNT_W'(HOLD_DEPTH)) begin
                    byte_out    <= hold_q[HOLD_DEPTH-1];
                    byte_valid  <= 1'b1;
                    frame_start <= (cnt_q == CNT_W'(HOLD_DEPTH));
                end
            end
            if (flag_pend_q) begin
                flag_seen <= 1'b1;
                if (full) begin
                    byte_out     <= hold_q[HOLD_DEPTH-1];
                    byte_valid   <= 1'b1;
                    frame_end    <= 1'b1;
                    frame_status <= (crc_q == CRC_GOOD && aligned_pend_q) ? FS_GOOD : FS_FCS_ERR;
                end
                cnt_q <= '0;
                crc_q <= CRC_PRESET;
            end
            if (abort_pend_q) begin
                abort_seen <= 1'b1;
                if (full) begin
                    frame_end    <= 1'b1;
                    frame_status <= FS_ABORT;
                end
                cnt_q <= '0;
                crc_q <= CRC_PRESET;
            end
        end
    end

    assert_start_has_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> byte_valid);

    assert_close_has_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && frame_status != FS_ABORT) |-> byte_valid);

    assert_abort_no_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && frame_status == FS_ABORT) |-> !byte_valid);

    assert_gap_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !byte_valid);

    assert_status_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |-> (frame_status == FS_NONE));

    assert_disable_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!byte_valid && !frame_end && !flag_seen && !abort_seen));

endmodule

// File: rtl/hdlc_deframer.sv
// Top level of the HDLC receive deframer. It chains bit delineation,
// octet packing and frame tracking. All outputs are registered, and all
// state clears while enable is low.
module hdlc_deframer
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       bit_in,
    input  logic       bit_valid,
    output logic [7:0] byte_out,
    output logic       byte_valid,
    output logic       frame_start,
    output logic       frame_end,
    output logic [1:0] frame_status,
    output logic       flag_seen,
    output logic       abort_seen
);
    logic               data_bit, data_ok, flag_hit, abort_hit;
    logic [OCTET_W-1:0] oct;
    logic               oct_stb, flag_ev, abort_ev, aligned;
    frame_status_e      status;

    hdlc_bit_delineator u_delin (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .data_bit  (data_bit),
        .data_ok   (data_ok),
        .flag_hit  (flag_hit),
        .abort_hit (abort_hit)
    );

    hdlc_octet_packer u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .data_bit   (data_bit),
        .data_ok    (data_ok),
        .flag_hit   (flag_hit),
        .abort_hit  (abort_hit),
        .oct_q      (oct),
        .oct_stb_q  (oct_stb),
        .flag_ev_q  (flag_ev),
        .abort_ev_q (abort_ev),
        .aligned_q  (aligned)
    );

    hdlc_frame_tracker u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .oct          (oct),
        .oct_stb      (oct_stb),
        .flag_ev      (flag_ev),
        .abort_ev     (abort_ev),
        .aligned      (aligned),
        .byte_out     (byte_out),
        .byte_valid   (byte_valid),
        .frame_start  (frame_start),
        .frame_end    (frame_end),
        .frame_status (status),
        .flag_seen    (flag_seen),
        .abort_seen   (abort_seen)
    );

    // Present the status enum as a plain vector at the port.
    always_comb frame_status = status;

endmodule

// File: tb/hdlc_deframer_bench.sv
module hdlc_deframer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       bit_in = 1'b1;
    logic       bit_valid = 1'b0;
    logic [7:0] byte_out;
    logic       byte_valid, frame_start, frame_end, flag_seen, abort_seen;
    logic [1:0] frame_status;

    hdlc_deframer u_hdlc_deframer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_in(bit_in),
        .bit_valid(bit_valid), .byte_out(byte_out), .byte_valid(byte_valid),
        .frame_start(frame_start), .frame_end(frame_end),
        .frame_status(frame_status), .flag_seen(flag_seen), .abort_seen(abort_seen)
    );

    always #4 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0, last_edge = 0, tb_ones = 0;
    bit done = 1'b0;
    logic [7:0] rx_q [0:255];
    logic [7:0] exp_q [0:255];
    int rx_n, start_n, end_n, flag_n, abort_n, end_cyc, start_cyc, abort_cyc, last_status;

    // Table: {body length, seed, corrupt FCS, pad bits, expected status (0 = dropped)}
    localparam int NVEC = 8;
    localparam logic [31:0] VECS [NVEC] = '{
        {8'd6,  8'h11, 4'd0, 4'd0, 8'd1},
        {8'd2,  8'h7E, 4'd0, 4'd0, 8'd1},
        {8'd20, 8'hFF, 4'd0, 4'd0, 8'd1},
        {8'd10, 8'h3C, 4'd1, 4'd0, 8'd2},
        {8'd1,  8'h55, 4'd0, 4'd0, 8'd0},
        {8'd8,  8'hA5, 4'd0, 4'd3, 8'd2},
        {8'd76, 8'h38, 4'd0, 4'd0, 8'd1},
        {8'd0,  8'h00, 4'd0, 4'd0, 8'd0}
    };

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (byte_valid) begin
            rx_q[rx_n[7:0]] = byte_out;
            rx_n++;
        end
        if (frame_start) begin start_n++; start_cyc = cyc; end
        if (frame_end) begin end_n++; end_cyc = cyc; last_status = int'(frame_status); end
        if (flag_seen) flag_n++;
        if (abort_seen) begin abort_n++; abort_cyc = cyc; end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        rx_n = 0; start_n = 0; end_n = 0; flag_n = 0; abort_n = 0;
        end_cyc = 0; start_cyc = 0; abort_cyc = 0; last_status = 0;
    endtask

    task automatic drive_raw(input logic b);
        @(negedge clk);
        bit_in = b; bit_valid = 1'b1;
        last_edge = cyc + 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b0;
        end
    endtask

    task automatic send_data_bit(input logic b);
        drive_raw(b);
        if (b) begin
            tb_ones++;
            if (tb_ones == 5) begin drive_raw(1'b0); tb_ones = 0; end
        end else tb_ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    task automatic send_flag();
        logic [7:0] f;
        f = 8'h7E;
        for (int i = 0; i < 8; i++) drive_raw(f[i]);
        tb_ones = 0;
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    function automatic logic [7:0] body_byte(input logic [7:0] seed, input int i);
        logic [7:0] t;
        t = 8'(i * 29);
        return (i % 2 == 1) ? seed : (seed ^ t);
    endfunction

    // Send body, check octets, pad bits and the closing flag; fill exp_q.
    task automatic send_frame(input int len, input logic [7:0] seed, input bit corrupt,
                              input int pad, output int close_edge);
        logic [15:0] crc;
        logic [15:0] fcs;
        crc = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            exp_q[i] = body_byte(seed, i);
            crc = ref_crc(crc, exp_q[i]);
            send_byte(exp_q[i]);
        end
        fcs = ~crc;
        if (corrupt) fcs = fcs ^ 16'h0001;
        send_byte(fcs[7:0]);
        send_byte(fcs[15:8]);
        for (int i = 0; i < pad; i++) send_data_bit(1'b0);
        send_flag();
        close_edge = last_edge;
    endtask

    function automatic int count_mismatch(input int n);
        int m;
        m = 0;
        for (int i = 0; i < n; i++) if (rx_q[i] != exp_q[i]) m++;
        return m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ce, e4, a7, len, pad, est;
        logic [7:0] seed;
        bit corrupt;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R12 reset byte_valid", int'(byte_valid), 0);
        chk("R12 reset frame_end", int'(frame_end), 0);
        chk("R12 reset frame_status", int'(frame_status), 0);
        chk("R9 reset flag_seen", int'(flag_seen), 0);

        // R2: data before any flag is ignored
        clear_mon();
        send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
        idle(4);
        chk("R2 bytes before flag", rx_n, 0);
        chk("R2 flags before flag", flag_n, 0);

        // Table-driven frames
        for (int v = 0; v < NVEC; v++) begin
            len = int'(VECS[v][31:24]);
            seed = VECS[v][23:16];
            corrupt = VECS[v][12];
            pad = int'(VECS[v][11:8]);
            est = int'(VECS[v][7:0]);
            clear_mon();
            send_flag();
            send_frame(len, seed, corrupt, pad, ce);
            idle(4);
            chk("R9 flag count per frame", flag_n, 2);
            if (est == 0) begin
                chk("R11 short frame bytes", rx_n, 0);
                chk("R11 short frame start", start_n, 0);
                chk("R11 short frame end", end_n, 0);
            end else begin
                chk("R4 start pulses", start_n, 1);
                chk("R5 byte count without FCS", rx_n, len);
                chk("R4 R3 byte content mismatches", count_mismatch(len), 0);
                chk("R5 end pulses", end_n, 1);
                if (est == 1) chk("R6 good status", last_status, 1);
                else          chk("R7 error status", last_status, 2);
                chk("R9 end latency", end_cyc - ce, 2);
            end
        end

        // R10: shared flag between two frames
        clear_mon();
        send_flag();
        send_frame(4, 8'h5A, 1'b0, 0, ce);
        for (int i = 0; i < 4; i++) exp_q[100 + i] = exp_q[i];
        send_frame(3, 8'hC3, 1'b0, 0, ce);
        idle(4);
        chk("R10 shared flag ends", end_n, 2);
        chk("R10 shared flag starts", start_n, 2);
        chk("R10 shared flag count", flag_n, 3);
        chk("R10 shared flag bytes", rx_n, 7);
        if (rx_n == 7) begin
            int m;
            m = 0;
            for (int i = 0; i < 4; i++) if (rx_q[i] != exp_q[100 + i]) m++;
            for (int i = 0; i < 3; i++) if (rx_q[4 + i] != exp_q[i]) m++;
            chk("R10 shared flag content", m, 0);
        end
        chk("R6 second frame status", last_status, 1);

        // R8 and R4: abort after start, with latency checks
        clear_mon();
        send_flag();
        e4 = 0;
        for (int i = 1; i <= 6; i++) begin
            send_byte(8'(i));
            if (i == 4) e4 = last_edge;
        end
        for (int i = 0; i < 7; i++) drive_raw(1'b1);
        a7 = last_edge;
        drive_raw(1'b1);
        tb_ones = 0;
        idle(4);
        chk("R4 first byte latency", start_cyc - e4, 9);
        chk("R8 abort pulse", abort_n, 1);
        chk("R8 abort end", end_n, 1);
        chk("R8 abort status", last_status, 3);
        chk("R8 bytes before abort", rx_n, 2);
        chk("R9 abort latency", abort_cyc - a7, 2);
        // Recovery after abort
        clear_mon();
        send_flag();
        send_frame(5, 8'h21, 1'b0, 0, ce);
        idle(4);
        chk("R8 recovery status", last_status, 1);
        chk("R8 recovery end", end_n, 1);

        // R8: abort before the frame started
        clear_mon();
        send_flag();
        send_byte(8'h01); send_byte(8'h02);
        for (int i = 0; i < 8; i++) drive_raw(1'b1);
        tb_ones = 0;
        idle(4);
        chk("R8 early abort pulse", abort_n, 1);
        chk("R8 early abort no end", end_n, 0);

        // R1: disable mid-frame, flag while disabled, then re-enable
        clear_mon();
        send_flag();
        for (int i = 1; i <= 5; i++) send_byte(8'(i));
        @(negedge clk);
        enable = 1'b0;
        send_flag();
        @(negedge clk);
        enable = 1'b1;
        send_frame(6, 8'h44, 1'b0, 0, ce);
        idle(4);
        chk("R1 no end after disable", end_n, 0);
        chk("R1 flag during disable ignored", flag_n, 2);
        clear_mon();
        send_frame(6, 8'h66, 1'b0, 0, ce);
        idle(4);
        chk("R1 frame after re-enable", last_status, 1);
        chk("R1 bytes after re-enable", rx_n, 6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule